// File: doc/BRIEF.md
# MSI Vector Capture Unit

This unit sits on the inbound write path of a PCIe root port bridge. It watches each inbound memory write, presented as an address, a data word and a valid strobe. A write whose address matches the configured message target address is a message-signalled interrupt. Its data value names one of 32 vectors, and the unit records that vector as a bit in a 32-bit pending register.

Any accepted vector also raises a single summary request, which feeds one bit of the local interrupt status. Software handles the two levels in order:

1. It clears the summary with a one-to-clear strobe.
2. It reads the pending register.
3. It retires each serviced vector by writing a mask in which a 1 clears the matching pending bit.

If vectors are still pending after such a clear, the summary request rises again, so a vector is never left stranded behind a cleared summary. Decoding packets into address and data, and setting up the message capability, happen elsewhere.

Top module: `msi_vector_capture`

## Requirements
- R1: After reset, and one cycle after any later reset, `pend_vec` is 0 and `sum_req` is 0.
- R2: A write with `wr_valid` high, `wr_addr` equal to `TARGET_ADDR` (default 0x190) and `wr_data` below 32 sets `pend_vec[wr_data]` at the next clock edge. Vector 0 and vector 31 are both accepted.
- R3: A write with `wr_valid` low, or with `wr_addr` not equal to `TARGET_ADDR`, changes neither `pend_vec` nor `sum_req`.
- R4: A target write whose `wr_data` is 32 or above sets no pending bit and does not raise `sum_req`.
- R5: With `clr_valid` high, every bit of `pend_vec` whose `clr_mask` bit is 1 reads 0 after the next edge. Bits whose mask bit is 0 are kept.
- R6: A vector that arrives while its bit is already pending leaves `pend_vec` unchanged, and still raises `sum_req`.
- R7: When a vector arrives in the same cycle as a clear of that same bit, the bit stays set.
- R8: `sum_req` is 1 in the cycle after any accepted vector.
- R9: `sum_clr` drops `sum_req` at the next edge when neither a vector nor a pending clear arrives in that cycle, even though `pend_vec` is nonzero.
- R10: A pending clear that leaves any bit of `pend_vec` still set makes `sum_req` 1 at the next edge. A clear that empties the register does not raise it.
- R11: An accepted vector in the same cycle as `sum_clr` leaves `sum_req` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Inbound write strobe |
| wr_addr | input | ADDR_W (32) | Inbound write address |
| wr_data | input | DATA_W (32) | Inbound write data, used as the vector number |
| clr_valid | input | 1 | Pending-register clear strobe |
| clr_mask | input | NUM_VEC (32) | One-to-clear mask for the pending register |
| sum_clr | input | 1 | One-to-clear strobe for the summary request |
| pend_vec | output | NUM_VEC (32) | Pending vectors |
| sum_req | output | 1 | Summary request toward the local interrupt status |

## Verification
The checker assumes that every input has a known value during each clock edge once reset is released. It also assumes that a target write and a clear can coincide in any combination, so it forms its own view of whether a write is accepted from the raw address, data and valid ports.

The stimulus applies every input at the falling edge and holds it through the following rising edge. Each row of the table covers one edge, so each property sees exactly one step of stimulus. The rows cover both range boundaries of the vector number, a non-target address, a dropped strobe, and the collisions of arrival with both kinds of clear.

// File: rtl/msi_vector_capture.sv
module msi_vector_capture #(
  parameter int NUM_VEC = 32,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] TARGET_ADDR = 'h190
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               clr_valid,
  input  logic [NUM_VEC-1:0] clr_mask,
  input  logic               sum_clr,
  output logic [NUM_VEC-1:0] pend_vec,
  output logic               sum_req
);
  localparam int IDX_W = $clog2(NUM_VEC);
  localparam logic [NUM_VEC-1:0] ONE = NUM_VEC'(1);

  logic               accept;
  logic [NUM_VEC-1:0] set_bits;
  logic [NUM_VEC-1:0] keep_bits;
  logic [NUM_VEC-1:0] pend_nxt;
  logic               sum_set;

  assign accept    = wr_valid && (wr_addr == TARGET_ADDR) && (wr_data < DATA_W'(NUM_VEC));
  assign set_bits  = accept ? (ONE << wr_data[IDX_W-1:0]) : '0;
  assign keep_bits = clr_valid ? (pend_vec & ~clr_mask) : pend_vec;
  assign pend_nxt  = keep_bits | set_bits;
  assign sum_set   = accept || (clr_valid && (pend_nxt != '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vec <= '0;
      sum_req  <= 1'b0;
    end else begin
      pend_vec <= pend_nxt;
      if (sum_set)
        sum_req <= 1'b1;
      else if (sum_clr)
        sum_req <= 1'b0;
    end
  end
endmodule

// File: rtl/msi_vector_capture_chk.sv
module msi_vector_capture_chk #(
  parameter int NUM_VEC = 32,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] TARGET_ADDR = 'h190
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_valid,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic               clr_valid,
  input logic [NUM_VEC-1:0] clr_mask,
  input logic               sum_clr,
  input logic [NUM_VEC-1:0] pend_vec,
  input logic               sum_req
);
  localparam int IDX_W = $clog2(NUM_VEC);
  logic hit;
  assign hit = wr_valid && (wr_addr == TARGET_ADDR) && (wr_data < DATA_W'(NUM_VEC));

  // R2
  vec_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend_vec[$past(wr_data[IDX_W-1:0])]);

  // R3
  no_stray_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ((pend_vec & ~$past(pend_vec)) == '0));

  // R5
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && !hit) |=> ((pend_vec & $past(clr_mask)) == '0));

  // R8
  summary_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> sum_req);

  // R9
  summary_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_clr && !hit && !clr_valid) |=> !sum_req);

  // R10
  summary_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sum_req) |-> $past(hit || clr_valid));
endmodule

bind msi_vector_capture msi_vector_capture_chk #(
  .NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TARGET_ADDR(TARGET_ADDR)
) u_chk (.*);

// File: tb/test_msi_vector_capture.sv
module test_msi_vector_capture;
  typedef struct packed {
    logic        wv;
    logic [31:0] addr;
    logic [31:0] data;
    logic        cv;
    logic [31:0] cmask;
    logic        sc;
    logic [31:0] epend;
    logic        esum;
    logic [7:0]  req;
  } vec_t;

  localparam logic [31:0] T = 32'h190;
  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1'b1, T,        32'd5,  1'b0, 32'h0,        1'b0, 32'h0000_0020, 1'b1, 8'd2},  // R2 R8
    '{1'b1, 32'h194,  32'd7,  1'b0, 32'h0,        1'b0, 32'h0000_0020, 1'b1, 8'd3},  // R3 other address
    '{1'b0, 32'h0,    32'd0,  1'b0, 32'h0,        1'b1, 32'h0000_0020, 1'b0, 8'd9},  // R9
    '{1'b1, T,        32'd40, 1'b0, 32'h0,        1'b0, 32'h0000_0020, 1'b0, 8'd4},  // R4
    '{1'b1, T,        32'd31, 1'b0, 32'h0,        1'b0, 32'h8000_0020, 1'b1, 8'd2},  // R2 top vector
    '{1'b1, T,        32'd0,  1'b0, 32'h0,        1'b0, 32'h8000_0021, 1'b1, 8'd2},  // R2 vector 0
    '{1'b0, 32'h0,    32'd0,  1'b0, 32'h0,        1'b1, 32'h8000_0021, 1'b0, 8'd9},  // R9
    '{1'b1, T,        32'd5,  1'b0, 32'h0,        1'b0, 32'h8000_0021, 1'b1, 8'd6},  // R6 duplicate
    '{1'b0, 32'h0,    32'd0,  1'b0, 32'h0,        1'b1, 32'h8000_0021, 1'b0, 8'd9},  // R9
    '{1'b0, 32'h0,    32'd0,  1'b1, 32'h1,        1'b0, 32'h8000_0020, 1'b1, 8'd10}, // R10 R5
    '{1'b1, T,        32'd3,  1'b0, 32'h0,        1'b1, 32'h8000_0028, 1'b1, 8'd11}, // R11
    '{1'b0, T,        32'd9,  1'b0, 32'h0,        1'b1, 32'h8000_0028, 1'b0, 8'd3},  // R3 strobe low
    '{1'b1, T,        32'd3,  1'b1, 32'h8,        1'b0, 32'h8000_0028, 1'b1, 8'd7},  // R7
    '{1'b0, 32'h0,    32'd0,  1'b0, 32'h0,        1'b1, 32'h8000_0028, 1'b0, 8'd9},  // R9
    '{1'b0, 32'h0,    32'd0,  1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0,        1'b0, 8'd5},  // R5 R10 empty
    '{1'b1, T,        32'd32, 1'b0, 32'h0,        1'b0, 32'h0,         1'b0, 8'd4}   // R4 boundary
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, clr_valid = 1'b0, sum_clr = 1'b0;
  logic [31:0] wr_addr = '0, wr_data = '0, clr_mask = '0;
  logic [31:0] pend_vec;
  logic sum_req;
  int applied = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  msi_vector_capture i_msi_vector_capture (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .clr_valid(clr_valid), .clr_mask(clr_mask), .sum_clr(sum_clr),
    .pend_vec(pend_vec), .sum_req(sum_req));

  task automatic check(input string req, input logic [31:0] ep, input logic es);
    applied++;
    if (pend_vec !== ep || sum_req !== es) begin
      bad++;
      $display("FAIL %s: pend=%h sum=%b expected pend=%h sum=%b", req, pend_vec, sum_req, ep, es);
    end
  endtask

  task automatic idle();
    wr_valid = 0; wr_addr = '0; wr_data = '0; clr_valid = 0; clr_mask = '0; sum_clr = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 reset", 32'h0, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_valid = TBL[i].wv; wr_addr = TBL[i].addr; wr_data = TBL[i].data;
      clr_valid = TBL[i].cv; clr_mask = TBL[i].cmask; sum_clr = TBL[i].sc;
      @(posedge clk);
      #1 check($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].epend, TBL[i].esum);
    end
    @(negedge clk);
    idle(); wr_valid = 1; wr_addr = T; wr_data = 32'd1;
    @(posedge clk);
    #1 check("R2 before reset", 32'h2, 1'b1);
    @(negedge clk);
    idle(); rst_n = 1'b0;
    @(posedge clk);
    #1 check("R1 mid-run reset", 32'h0, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1 check("R1 held after reset", 32'h0, 1'b0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 2000 && !done; c++) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule